// File: doc/BRIEF.md
# Debug Bus Cycle Stealing Arbiter

This block lets a debug command engine reach the system bus that a running CPU already uses. The debug side posts one access at a time: an address, optional write data, a direction flag and a length in bus cycles. The arbiter then watches the CPU's bus-use indication and places the first beat in a cycle the CPU leaves idle, so the program keeps running undisturbed.

Two rules ensure that every access finishes. If the CPU keeps the bus busy for a fixed window of 128 consecutive waiting cycles, the arbiter freezes the CPU and takes the bus. If an access needs more than one bus cycle, the CPU is frozen from the second beat until the last, even when the first beat used a naturally idle cycle. When the access finishes, the requester receives a single-cycle completion pulse and the read data sampled on the final beat. The arbiter has no mode input and behaves the same whether or not the system is halted for debugging.

Top module: `dbg_steal_arb`

## Requirements
- R1: After synchronous reset, `busy`, `dbg_grant`, `cpu_freeze` and `done` are all low.
- R2: A request presented while `busy` is low is accepted at that clock edge, and `busy` is high in the following cycle.
- R3: `dbg_grant` is high only in a cycle where `cpu_bus_busy` is low or `cpu_freeze` is high, and only while a request is in progress.
- R4: A request with `req_extra` = 0 (one beat) whose wait ends in a cycle with `cpu_bus_busy` low is granted in that cycle and never raises `cpu_freeze`.
- R5: Count the first cycle after acceptance as waiting cycle 0. If `cpu_bus_busy` is high in waiting cycles 0 through 127, then in cycle 128 `cpu_freeze` and `dbg_grant` are both high, and `cpu_freeze` is low in every earlier cycle.
- R6: An access has `req_extra`+1 beats in consecutive cycles. If the first beat used an idle cycle, `cpu_freeze` is low on that beat and high on every later beat.
- R7: `cpu_freeze` falls in the cycle after the final beat. In that cycle `done` is high for exactly one cycle, `busy` is low, and `rsp_rdata` holds the `bus_rdata` value present during the final beat.
- R8: A request presented while `busy` is high is ignored. Address, data, direction and length of the access in progress stay unchanged.
- R9: On beat n (counted from 0), `bus_addr` equals the accepted address plus n, modulo 2^16. `bus_wdata` and `bus_write` carry the accepted values.
- R10: The 128-cycle window restarts for each new request, even directly after a request that ended by timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Debug side presents an access |
| req_addr | input | 16 | Start address of the access |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_extra | input | 4 | Number of beats minus one |
| busy | output | 1 | An access is in progress; new requests are ignored |
| cpu_bus_busy | input | 1 | CPU uses the bus in this cycle |
| cpu_freeze | output | 1 | Hold the CPU still |
| dbg_grant | output | 1 | Bus belongs to the debug side this cycle |
| bus_addr | output | 16 | Address of the current beat |
| bus_wdata | output | 16 | Write data for the bus |
| bus_write | output | 1 | Direction of the current beat |
| bus_rdata | input | 16 | Read data returned by the bus |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured on the final beat |

## Verification
A corrupted wait counter shows at the ports as a freeze that arrives early or late relative to cycle 128. The bench compares the exact freeze cycle for waits just below, at and above the window, so such a fault is caught within one access. A wrong beat count or index shows within a cycle as a grant that lasts too long or stops too early, a misplaced `done`, or a wrong `bus_addr`. A stuck state shows as `dbg_grant` while the CPU runs unfrozen, or as `busy` staying high after `done`, which the checks catch in the same cycle.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned LEN_W  = 4;
    localparam int unsigned BEAT_W = LEN_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic [LEN_W-1:0]  extra;
    } dbg_req_t;

    function automatic logic [BEAT_W-1:0] beats_of(input logic [LEN_W-1:0] extra);
        return {1'b0, extra} + BEAT_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [LEN_W-1:0]  idx);
        return base + ADDR_W'(idx);
    endfunction
endpackage

// File: rtl/dsa_req_latch.sv
module dsa_req_latch
    import dsa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dbg_req_t req_in,
    output dbg_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (load) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/dsa_wait_timer.sv
module dsa_wait_timer #(
    parameter int unsigned WAIT_LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic at_limit
);
    localparam int unsigned CNT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign at_limit = (cnt == LAST);
endmodule

// File: rtl/dsa_beat_ctr.sv
module dsa_beat_ctr
    import dsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BEAT_W-1:0] load_left,
    input  logic [LEN_W-1:0]  load_idx,
    input  logic              step,
    output logic [LEN_W-1:0]  idx,
    output logic              last
);
    logic [BEAT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            idx  <= '0;
        end else if (load) begin
            left <= load_left;
            idx  <= load_idx;
        end else if (step) begin
            left <= left - BEAT_W'(1);
            idx  <= idx + LEN_W'(1);
        end
    end

    assign last = (left == BEAT_W'(1));
endmodule

// File: rtl/dbg_steal_arb.sv
module dbg_steal_arb
    import dsa_pkg::*;
#(
    parameter int unsigned WAIT_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_extra,
    output logic              busy,
    input  logic              cpu_bus_busy,
    output logic              cpu_freeze,
    output logic              dbg_grant,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_write,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata
);
    arb_state_e state, state_nxt;
    dbg_req_t   req_in, req_q;

    logic              accept, finish;
    logic              tmr_clear, tmr_tick, tmr_at_limit;
    logic              beat_load, beat_step, beat_last;
    logic [BEAT_W-1:0] beat_left_init;
    logic [LEN_W-1:0]  beat_idx_init, beat_idx, cur_idx;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write, extra: req_extra};

    dsa_req_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    dsa_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (tmr_clear),
        .tick     (tmr_tick),
        .at_limit (tmr_at_limit)
    );

    dsa_beat_ctr u_beats (
        .clk       (clk),
        .rst       (rst),
        .load      (beat_load),
        .load_left (beat_left_init),
        .load_idx  (beat_idx_init),
        .step      (beat_step),
        .idx       (beat_idx),
        .last      (beat_last)
    );

    always_comb begin
        state_nxt      = state;
        accept         = 1'b0;
        finish         = 1'b0;
        tmr_clear      = 1'b0;
        tmr_tick       = 1'b0;
        beat_load      = 1'b0;
        beat_step      = 1'b0;
        beat_left_init = '0;
        beat_idx_init  = '0;
        cur_idx        = '0;
        dbg_grant      = 1'b0;
        cpu_freeze     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    tmr_clear = 1'b1;
                    state_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!cpu_bus_busy) begin
                    // first beat rides on a naturally idle cycle
                    dbg_grant = 1'b1;
                    tmr_clear = 1'b1;
                    if (req_q.extra == '0) begin
                        finish    = 1'b1;
                        state_nxt = ST_IDLE;
                    end else begin
                        beat_load      = 1'b1;
                        beat_left_init = {1'b0, req_q.extra};
                        beat_idx_init  = LEN_W'(1);
                        state_nxt      = ST_XFER;
                    end
                end else if (tmr_at_limit) begin
                    // window exhausted: all beats run with the CPU frozen
                    tmr_clear      = 1'b1;
                    beat_load      = 1'b1;
                    beat_left_init = beats_of(req_q.extra);
                    beat_idx_init  = '0;
                    state_nxt      = ST_XFER;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_XFER: begin
                dbg_grant  = 1'b1;
                cpu_freeze = 1'b1;
                cur_idx    = beat_idx;
                beat_step  = 1'b1;
                if (beat_last) begin
                    finish    = 1'b1;
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state  <= state_nxt;
            done_q <= finish;
            if (finish) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    assign busy      = (state != ST_IDLE);
    assign bus_addr  = beat_addr(req_q.addr, cur_idx);
    assign bus_wdata = req_q.wdata;
    assign bus_write = req_q.write;
    assign done      = done_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
    parameter int unsigned WAIT_LIMIT = 128
) (
    input logic clk,
    input logic rst,
    input logic cpu_bus_busy,
    input logic dbg_grant,
    input logic cpu_freeze,
    input logic done,
    input logic busy
);
    localparam int unsigned CW = $clog2(WAIT_LIMIT + 2);

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy || dbg_grant) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + CW'(1);
        end
    end

    p_grant_safe_r3: assert property (@(posedge clk) disable iff (rst)
        dbg_grant |-> (!cpu_bus_busy || cpu_freeze));

    p_grant_in_progress_r3: assert property (@(posedge clk) disable iff (rst)
        dbg_grant |-> busy);

    p_freeze_with_grant_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_freeze |-> dbg_grant);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_released_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !cpu_freeze));

    p_freeze_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_freeze) |-> done);

    p_wait_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CW'(WAIT_LIMIT));
endmodule

bind dbg_steal_arb dsa_checker #(.WAIT_LIMIT(WAIT_LIMIT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_bus_busy (cpu_bus_busy),
    .dbg_grant    (dbg_grant),
    .cpu_freeze   (cpu_freeze),
    .done         (done),
    .busy         (busy)
);

// File: tb/dbg_steal_arb_tb_top.sv
module dbg_steal_arb_tb_top;
    import dsa_pkg::*;

    localparam int LIMIT = 128;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_write;
    logic [LEN_W-1:0]  req_extra;
    logic              busy;
    logic              cpu_bus_busy;
    logic              cpu_freeze;
    logic              dbg_grant;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_write;
    logic [DATA_W-1:0] bus_rdata;
    logic              done;
    logic [DATA_W-1:0] rsp_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit prev_timeout = 1'b0;

    always #5 clk = ~clk;

    dbg_steal_arb #(.WAIT_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_extra(req_extra),
        .busy(busy), .cpu_bus_busy(cpu_bus_busy), .cpu_freeze(cpu_freeze),
        .dbg_grant(dbg_grant), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_write(bus_write), .bus_rdata(bus_rdata), .done(done),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int first_beat(input int k);
        return (k < LIMIT) ? k : LIMIT;
    endfunction

    function automatic int first_frozen(input int k);
        return (k < LIMIT) ? k + 1 : LIMIT;
    endfunction

    // k = number of busy CPU cycles before the first idle one, ln = req_extra
    task automatic run_req(input int k, input int ln);
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] wd, exp_rd;
        logic              wr;
        int                st, fz, lst;
        string             ftag;
        bit                noise;
        base = ADDR_W'($urandom);
        wd   = DATA_W'($urandom);
        wr   = 1'($urandom);
        exp_rd = '0;
        st  = first_beat(k);
        fz  = first_frozen(k);
        lst = st + ln;
        if (k >= LIMIT) ftag = prev_timeout ? "R10" : "R5";
        else            ftag = (ln == 0) ? "R4" : "R6";

        @(negedge clk);
        req_valid    = 1'b1;
        req_addr     = base;
        req_wdata    = wd;
        req_write    = wr;
        req_extra    = LEN_W'(ln);
        cpu_bus_busy = 1'($urandom);
        bus_rdata    = DATA_W'($urandom);
        #4;
        chk("R2", "busy before accept", busy, 0);
        chk("R3", "grant while idle", dbg_grant, 0);

        for (int c = 0; c <= lst + 1; c++) begin
            bit eg, ef, ed;
            @(negedge clk);
            noise = (c <= lst) && ($urandom % 3 == 0);
            req_valid = noise;
            if (noise) begin
                req_addr  = ADDR_W'($urandom);
                req_wdata = DATA_W'($urandom);
                req_write = 1'($urandom);
                req_extra = LEN_W'($urandom);
            end
            cpu_bus_busy = (c < k) ? 1'b1 : ((c == k) ? 1'b0 : 1'($urandom));
            bus_rdata    = DATA_W'($urandom);
            #4;
            eg = (c >= st) && (c <= lst);
            ef = (c >= fz) && (c <= lst);
            ed = (c == lst + 1);
            if (c == 0) chk("R2", "busy after accept", busy, 1);
            chk("R3", "grant", dbg_grant, eg);
            chk(ftag, "freeze", cpu_freeze, ef);
            chk("R7", "done", done, ed);
            if (eg) begin
                chk(noise ? "R8" : "R9", "bus_addr", bus_addr, ADDR_W'(base + ADDR_W'(c - st)));
                chk(noise ? "R8" : "R9", "bus_wdata", bus_wdata, wd);
                chk("R9", "bus_write", bus_write, wr);
            end
            if (c == lst) exp_rd = bus_rdata;
            if (ed) begin
                chk("R7", "rsp_rdata", rsp_rdata, exp_rd);
                chk("R7", "busy after done", busy, 0);
            end
        end
        prev_timeout = (k >= LIMIT);

        // idle gap: nothing may happen without a request
        for (int g = 0; g < 1 + int'($urandom % 3); g++) begin
            @(negedge clk);
            req_valid    = 1'b0;
            cpu_bus_busy = 1'($urandom);
            #4;
            chk("R3", "grant in gap", dbg_grant, 0);
            chk("R7", "done in gap", done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
        req_write = 1'b0; req_extra = '0; cpu_bus_busy = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        chk("R1", "busy", busy, 0);
        chk("R1", "grant", dbg_grant, 0);
        chk("R1", "freeze", cpu_freeze, 0);
        chk("R1", "done", done, 0);

        // directed corners
        run_req(0, 0);
        run_req(127, 0);
        run_req(128, 0);
        run_req(140, 1);
        run_req(0, 3);
        run_req(5, 15);
        run_req(130, 15);
        run_req(126, 2);

        // constrained random mix
        for (int i = 0; i < 30; i++) begin
            int sel, k;
            sel = int'($urandom % 10);
            if (sel < 6)      k = int'($urandom % 21);
            else if (sel < 8) k = 124 + int'($urandom % 8);
            else              k = 129 + int'($urandom % 50);
            run_req(k, int'($urandom % 16));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule